// File: doc/BRIEF.md
# Row-Hit-First Write Drain Scheduler

This block keeps a short queue of pending memory write requests, each labelled with a rank, a bank and a row. A drain pulse starts a batch. During the batch the block offers one write at a time on a valid/ready issue port.

Before each issue it scans the queue from the oldest entry to the newest. It picks the first entry whose row is the one currently open in that entry's bank. If no entry matches, it picks the oldest entry. The chosen entry leaves the queue, and the entries behind it close ranks with their relative order kept.

A batch ends when the number of writes issued in that batch reaches a threshold. The threshold is captured when the drain starts. A batch also ends when the queue runs dry. The end of a batch is signalled by a single-cycle done pulse.

A memory controller uses the block to group writes so that they are issued in bursts. The open-row table comes from its bank state. The threshold sets how long the data bus stays turned around for writes.

Top module: `wds_drain_sched`

## Requirements
- R1: After synchronous reset the queue is empty: `enq_full`, `iss_valid` and `drain_done` are all 0.
- R2: An enqueue with `enq_valid`=1, the queue not full, and a size within the burst limit is stored at the tail. `enq_full` is 1 exactly when DEPTH entries are held. While `enq_full` is 1, an enqueue is refused and not stored.
- R3: A request whose `enq_size` exceeds BURST_BYTES raises `enq_err` in the same cycle and is not stored.
- R4: `iss_valid` is 0 outside a batch. A batch starts on the clock edge after `drain_start` is sampled high while idle.
- R5: A queue holding a single entry issues that entry.
- R6: With more than one entry, the block issues the oldest entry that hits. An entry hits when `open_vld[s]` is 1 and `open_rows[s*ROW_W +: ROW_W]` equals its row. The slot index is s = {rank, bank}, with the rank in the upper bit.
- R7: When no queued entry hits, the oldest entry is issued.
- R8: After an entry is pulled forward from the middle of the queue, the remaining entries keep their relative age order.
- R9: Exactly one entry is removed per handshake (`iss_valid` and `iss_ready` both 1). While `iss_ready` is 0, the offered descriptor stays valid and unchanged, provided the open-row table is stable.
- R10: A batch ends once the number of writes issued in it is greater than or equal to the threshold captured at `drain_start`. A threshold of 0 issues nothing.
- R11: A batch ends when the queue becomes empty. Every batch ends with `drain_done` high for exactly one cycle, after which the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Enqueue request |
| enq_rank | input | RANK_W | Rank of request |
| enq_bank | input | BANK_W | Bank of request |
| enq_row | input | ROW_W | Row of request |
| enq_size | input | SIZE_W | Request size in bytes |
| enq_full | output | 1 | Queue holds DEPTH entries |
| enq_err | output | 1 | Request larger than one burst (refused) |
| open_rows | input | NUM_SLOTS*ROW_W | Open row per bank slot, slot s at bits s*ROW_W |
| open_vld | input | NUM_SLOTS | Row open flag per bank slot |
| drain_start | input | 1 | Start a write batch |
| drain_thr | input | THR_W | Maximum writes in the batch |
| iss_valid | output | 1 | Write descriptor offered |
| iss_ready | input | 1 | Downstream accepts descriptor |
| iss_rank | output | RANK_W | Issued rank |
| iss_bank | output | BANK_W | Issued bank |
| iss_row | output | ROW_W | Issued row |
| drain_done | output | 1 | One-cycle end-of-batch pulse |

## Verification
The bench builds the block with DEPTH=4 and keeps the default 4-bit threshold. A four-entry queue fills within a few enqueues, which brings the full-refusal path into easy reach. It also allows a threshold larger than the queue, so a batch can end by running dry, while small thresholds cut a batch short with entries left over. The two-rank, four-bank table means a rank-1 entry and a rank-0 entry that share a bank number map to different slots. That difference exercises the slot decode.

// File: rtl/wds_pkg.sv
package wds_pkg;
    localparam int RANK_W    = 1;
    localparam int BANK_W    = 2;
    localparam int ROW_W     = 8;
    localparam int SLOT_W    = RANK_W + BANK_W;
    localparam int NUM_SLOTS = 1 << SLOT_W;

    typedef struct packed {
        logic [RANK_W-1:0] rank;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
    } wr_desc_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_DRAIN = 1'b1
    } batch_st_t;

    function automatic logic [SLOT_W-1:0] slot_of(input wr_desc_t d);
        return {d.rank, d.bank};
    endfunction
endpackage

// File: rtl/wds_queue.sv
module wds_queue
    import wds_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  wr_desc_t         push_d,
    input  logic             pop,
    input  logic [IDX_W-1:0] pop_idx,
    output wr_desc_t         slots [DEPTH],
    output logic [CNT_W-1:0] occ
);
    wr_desc_t         nxt [DEPTH];
    logic [CNT_W-1:0] occ_mid;
    logic [CNT_W-1:0] occ_nxt;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) nxt[i] = slots[i];
        occ_mid = occ;
        if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (IDX_W'(i) >= pop_idx) nxt[i] = slots[i + 1];
            end
            occ_mid = occ - CNT_W'(1);
        end
        occ_nxt = occ_mid;
        if (push) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CNT_W'(i) == occ_mid) nxt[i] = push_d;
            end
            occ_nxt = occ_mid + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) occ <= '0;
        else     occ <= occ_nxt;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) slots[i] <= nxt[i];
    end
endmodule

// File: rtl/wds_picker.sv
module wds_picker
    import wds_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  wr_desc_t                  slots [DEPTH],
    input  logic [CNT_W-1:0]          occ,
    input  logic [NUM_SLOTS*ROW_W-1:0] open_rows,
    input  logic [NUM_SLOTS-1:0]      open_vld,
    output logic [IDX_W-1:0]          pick_idx,
    output logic                      pick_hit
);
    logic [DEPTH-1:0] hit_vec;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_hit
            logic [SLOT_W-1:0] s;
            assign s = slot_of(slots[g]);
            assign hit_vec[g] = (CNT_W'(g) < occ) && open_vld[s]
                              && (open_rows[s*ROW_W +: ROW_W] == slots[g].row);
        end
    endgenerate

    always_comb begin
        pick_idx = '0;
        pick_hit = 1'b0;
        if (occ > CNT_W'(1)) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (!pick_hit && hit_vec[i]) begin
                    pick_hit = 1'b1;
                    pick_idx = IDX_W'(i);
                end
            end
        end
    end
endmodule

// File: rtl/wds_batch_ctl.sv
module wds_batch_ctl
    import wds_pkg::*;
#(
    parameter int THR_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             drain_start,
    input  logic [THR_W-1:0] drain_thr,
    input  logic             q_empty,
    input  logic             fire,
    output logic             draining,
    output logic             issue_en,
    output logic             drain_done,
    output logic [THR_W-1:0] issued_cnt,
    output logic [THR_W-1:0] thr_lat
);
    batch_st_t st_q;
    logic      stop;

    assign draining   = (st_q == ST_DRAIN);
    assign stop       = (issued_cnt >= thr_lat) || q_empty;
    assign issue_en   = draining && !stop;
    assign drain_done = draining && stop;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            issued_cnt <= '0;
            thr_lat    <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (drain_start) begin
                    st_q       <= ST_DRAIN;
                    issued_cnt <= '0;
                    thr_lat    <= drain_thr;
                end
                ST_DRAIN: begin
                    if (stop)      st_q <= ST_IDLE;
                    else if (fire) issued_cnt <= issued_cnt + THR_W'(1);
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wds_drain_sched.sv
module wds_drain_sched
    import wds_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int THR_W       = 4,
    parameter int SIZE_W      = 8,
    parameter int BURST_BYTES = 64
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       enq_valid,
    input  logic [RANK_W-1:0]          enq_rank,
    input  logic [BANK_W-1:0]          enq_bank,
    input  logic [ROW_W-1:0]           enq_row,
    input  logic [SIZE_W-1:0]          enq_size,
    output logic                       enq_full,
    output logic                       enq_err,
    input  logic [NUM_SLOTS*ROW_W-1:0] open_rows,
    input  logic [NUM_SLOTS-1:0]       open_vld,
    input  logic                       drain_start,
    input  logic [THR_W-1:0]           drain_thr,
    output logic                       iss_valid,
    input  logic                       iss_ready,
    output logic [RANK_W-1:0]          iss_rank,
    output logic [BANK_W-1:0]          iss_bank,
    output logic [ROW_W-1:0]           iss_row,
    output logic                       drain_done
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [SIZE_W-1:0] SIZE_LIM = SIZE_W'(BURST_BYTES);

    wr_desc_t         slots [DEPTH];
    wr_desc_t         push_d;
    wr_desc_t         sel_d;
    logic [CNT_W-1:0] occ;
    logic [IDX_W-1:0] pick_idx;
    logic             pick_hit;
    logic             push, fire, draining, issue_en;
    logic [THR_W-1:0] issued_cnt, thr_lat;

    assign push_d   = '{rank: enq_rank, bank: enq_bank, row: enq_row};
    assign enq_full = (occ == CNT_W'(DEPTH));
    assign enq_err  = enq_valid && (enq_size > SIZE_LIM);
    assign push     = enq_valid && !enq_full && !enq_err;
    assign fire     = iss_valid && iss_ready;

    wds_queue #(.DEPTH(DEPTH)) u_queue (
        .clk(clk), .rst(rst), .push(push), .push_d(push_d),
        .pop(fire), .pop_idx(pick_idx), .slots(slots), .occ(occ)
    );

    wds_picker #(.DEPTH(DEPTH)) u_pick (
        .slots(slots), .occ(occ), .open_rows(open_rows), .open_vld(open_vld),
        .pick_idx(pick_idx), .pick_hit(pick_hit)
    );

    wds_batch_ctl #(.THR_W(THR_W)) u_ctl (
        .clk(clk), .rst(rst), .drain_start(drain_start), .drain_thr(drain_thr),
        .q_empty(occ == '0), .fire(fire), .draining(draining),
        .issue_en(issue_en), .drain_done(drain_done),
        .issued_cnt(issued_cnt), .thr_lat(thr_lat)
    );

    assign sel_d     = slots[pick_idx];
    assign iss_valid = issue_en;
    assign iss_rank  = sel_d.rank;
    assign iss_bank  = sel_d.bank;
    assign iss_row   = sel_d.row;
endmodule

module wds_drain_sched_chk #(
    parameter int DEPTH = 8,
    parameter int THR_W = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             enq_valid,
    input logic             enq_full,
    input logic             enq_err,
    input logic             iss_valid,
    input logic             iss_ready,
    input logic             drain_done,
    input logic             draining,
    input logic [CNT_W-1:0] occ,
    input logic [THR_W-1:0] issued_cnt,
    input logic [THR_W-1:0] thr_lat
);
    p_occ_bound_r2: assert property (@(posedge clk) disable iff (rst)
        occ <= CNT_W'(DEPTH));

    p_full_refuse_r2: assert property (@(posedge clk) disable iff (rst)
        (enq_valid && enq_full && !(iss_valid && iss_ready)) |=> $stable(occ));

    p_err_no_store_r3: assert property (@(posedge clk) disable iff (rst)
        (enq_err && !(iss_valid && iss_ready)) |=> $stable(occ));

    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !draining |-> !iss_valid);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !iss_ready && !enq_valid) |=> $stable(occ));

    p_thr_cap_r10: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> (issued_cnt < thr_lat));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        drain_done |=> !drain_done);
endmodule

bind wds_drain_sched wds_drain_sched_chk #(.DEPTH(DEPTH), .THR_W(THR_W)) u_chk (
    .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_full(enq_full),
    .enq_err(enq_err), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .drain_done(drain_done), .draining(draining), .occ(occ),
    .issued_cnt(issued_cnt), .thr_lat(thr_lat)
);

// File: tb/wds_drain_sched_test.sv
module wds_drain_sched_test;
    import wds_pkg::*;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4;
    localparam int THR_W = 4;
    localparam int DW = RANK_W + BANK_W + ROW_W;

    logic clk = 0, rst = 1;
    logic enq_valid = 0;
    logic [RANK_W-1:0] enq_rank = 0;
    logic [BANK_W-1:0] enq_bank = 0;
    logic [ROW_W-1:0] enq_row = 0;
    logic [7:0] enq_size = 0;
    logic enq_full, enq_err;
    logic [NUM_SLOTS*ROW_W-1:0] open_rows = 0;
    logic [NUM_SLOTS-1:0] open_vld = 0;
    logic drain_start = 0;
    logic [THR_W-1:0] drain_thr = 0;
    logic iss_valid, iss_ready = 1;
    logic [RANK_W-1:0] iss_rank;
    logic [BANK_W-1:0] iss_bank;
    logic [ROW_W-1:0] iss_row;
    logic drain_done;

    int errors = 0, checks = 0;
    bit finished = 0;
    logic [DW-1:0] model_q[$];
    logic [DW-1:0] exp_q[$];
    string cur_req = "R7";

    always #(CLK_PERIOD/2) clk = ~clk;

    wds_drain_sched #(.DEPTH(DEPTH), .THR_W(THR_W)) uut (
        .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_rank(enq_rank),
        .enq_bank(enq_bank), .enq_row(enq_row), .enq_size(enq_size),
        .enq_full(enq_full), .enq_err(enq_err), .open_rows(open_rows),
        .open_vld(open_vld), .drain_start(drain_start), .drain_thr(drain_thr),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_rank(iss_rank),
        .iss_bank(iss_bank), .iss_row(iss_row), .drain_done(drain_done)
    );

    task automatic check(input string req, input bit ok, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected issues as handshakes occur
    always @(negedge clk) begin
        #2;
        if (!rst && iss_valid && iss_ready) begin
            if (exp_q.size() == 0) begin
                check(cur_req, 0, {iss_rank, iss_bank, iss_row}, 32'hFFFF);
            end else begin
                logic [DW-1:0] e;
                e = exp_q.pop_front();
                check(cur_req, {iss_rank, iss_bank, iss_row} == e, {iss_rank, iss_bank, iss_row}, e);
            end
        end
    end

    function automatic bit model_hit(input logic [DW-1:0] d);
        logic [SLOT_W-1:0] s;
        s = d[DW-1 -: SLOT_W];
        return open_vld[s] && (open_rows[s*ROW_W +: ROW_W] == d[ROW_W-1:0]);
    endfunction

    task automatic set_open(input int slot, input bit v, input logic [ROW_W-1:0] row);
        open_vld[slot] = v;
        open_rows[slot*ROW_W +: ROW_W] = row;
    endtask

    task automatic enq(input int rk, input int bk, input int rw, input int sz);
        bit exp_full, exp_err;
        @(negedge clk);
        enq_valid = 1; enq_rank = RANK_W'(rk); enq_bank = BANK_W'(bk);
        enq_row = ROW_W'(rw); enq_size = 8'(sz);
        #1;
        exp_full = (model_q.size() == DEPTH);
        exp_err = (sz > 64);
        check("R2 full flag", enq_full == exp_full, enq_full, exp_full);
        check("R3 size error", enq_err == exp_err, enq_err, exp_err);
        if (!exp_full && !exp_err) model_q.push_back({enq_rank, enq_bank, enq_row});
        @(negedge clk);
        enq_valid = 0;
    endtask

    // builds expected issue order, then runs a batch
    task automatic drain(input int thr, input bit toggle, input string req);
        int n = 0, dones = 0, cyc = 0;
        bit hold = 0;
        logic [DW-1:0] held;
        cur_req = req;
        while (n < thr && model_q.size() > 0) begin
            int k = 0;
            if (model_q.size() > 1) begin
                for (int i = model_q.size() - 1; i >= 0; i--)
                    if (model_hit(model_q[i])) k = i;
            end
            exp_q.push_back(model_q[k]);
            model_q.delete(k);
            n++;
        end
        @(negedge clk);
        drain_start = 1; drain_thr = THR_W'(thr); iss_ready = 1;
        @(negedge clk);
        drain_start = 0;
        while (dones == 0 && cyc < 100) begin
            if (cyc > 0) @(negedge clk);
            iss_ready = toggle ? cyc[0] : 1'b1;
            #3;
            if (hold) begin
                check("R9 hold", iss_valid && {iss_rank, iss_bank, iss_row} == held,
                      {iss_rank, iss_bank, iss_row}, held);
                hold = 0;
            end
            if (iss_valid && !iss_ready) begin
                hold = 1;
                held = {iss_rank, iss_bank, iss_row};
            end
            if (drain_done) dones++;
            cyc++;
        end
        check("R11 done seen", dones == 1, dones, 1);
        @(negedge clk);
        #3;
        check("R11 single pulse", !drain_done && !iss_valid, {drain_done, iss_valid}, 0);
        check("R10 batch count", exp_q.size() == 0, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        check("R1 reset", !enq_full && !iss_valid && !drain_done,
              {enq_full, iss_valid, drain_done}, 0);

        // R3: oversize refused, R2: fill then refuse
        enq(0, 0, 1, 65);
        enq(0, 0, 10, 64);
        enq(0, 1, 11, 8);
        enq(1, 2, 12, 32);
        enq(0, 3, 13, 16);
        enq(0, 2, 14, 16);   // refused: full
        // R4: nothing issued while idle
        @(negedge clk); #3;
        check("R4 idle quiet", !iss_valid, iss_valid, 0);
        // R7, R11: no open rows, oldest first until empty
        drain(15, 0, "R7 oldest");

        // R5: single entry
        set_open(1, 1, 8'd99);
        enq(0, 1, 40, 8);
        drain(3, 0, "R5 single");

        // R6, R10, R8: pulled forward and threshold cap
        enq(0, 0, 5, 8);     // slot0 row5
        enq(0, 1, 7, 8);     // slot1 row7 (open row 9: miss)
        enq(0, 1, 9, 8);     // slot1 row9 hit
        enq(1, 2, 3, 8);     // slot6 row3 hit
        set_open(1, 1, 8'd9);
        set_open(6, 1, 8'd3);
        set_open(2, 1, 8'd3); // rank0 bank2 must not match rank1 entry's slot
        set_open(2, 0, 8'd3);
        drain(2, 0, "R6 hit first");
        drain(15, 0, "R8 order kept");

        // R6: slot decode, rank1 vs rank0 same bank
        set_open(2, 1, 8'd20);
        set_open(6, 0, 8'd0);
        enq(1, 2, 20, 8);    // slot6, closed: miss
        enq(0, 2, 20, 8);    // slot2 row20: hit
        drain(1, 0, "R6 slot decode");
        drain(15, 0, "R6 remainder");

        // R10: threshold 0 issues nothing
        enq(0, 3, 50, 8);
        drain(0, 0, "R10 zero thr");
        // R9: ready toggling
        enq(0, 0, 51, 8);
        enq(0, 1, 52, 8);
        drain(15, 1, "R9 handshake");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule